// File: doc/BRIEF.md
# Real-Time Clock Time Counter

This block keeps the time of day and the calendar for a real-time clock. A one-second strobe from an external divider advances it. Each strobe moves the seconds field forward, and carries ripple into minutes, hours, day of week, date, month and year. Software sets the fields and a small control byte through a simple write port. The fields are held in the form that software reads and writes. That form is BCD or plain binary, and the hours can be 12-hour or 24-hour. A one-cycle update-ended pulse goes to the interrupt logic. A gated copy of that pulse is also provided, qualified by an enable bit.

The counter can also apply daylight-saving changes. In spring, 1:59:59 AM is followed directly by 3:00:00 AM. In autumn, the first pass through 1:59:59 AM is followed by 1:00:00 AM, and the second pass carries on normally. A change only takes effect when the clock has been ticking without software interference for at least two strobes before the trigger second. The power-well reset clears only the interrupt enable and the internal daylight-saving history. The mode bits are kept through every reset. The time fields behave as battery-held storage and are set by software.

Top module: `rtc_time_counter`

## Requirements
- R1: Control bit 2 (write address 7) selects the number format of every field, 0 for BCD and 1 for binary. For example, seconds 9 advance to 0x10 in BCD and to 0x0A in binary.
- R2: Control bit 1 set selects 24-hour mode, in which hour 23 at 59:59 rolls to hour 0 and bit 7 of the hour stays 0.
- R3: With control bit 1 clear, hour bit 7 is the PM flag (1 = PM). Hours step 11 AM to 12 PM, 12 PM to 1 PM, and 11 PM to 12 AM, and the last of these advances the date.
- R4: Seconds and minutes roll from 59 to 0 and carry into the next field. When seconds do not roll, minutes stay unchanged.
- R5: The date rolls at the month length (30 or 31, February 28, or 29 when the year is divisible by 4). Month 12 rolls to 1 and year 99 rolls to 0.
- R6: Day of week counts 1 to 7 (1 = Sunday) and advances with the date, 7 wrapping to 1.
- R7: With control bit 0 set, on a Sunday in April with date 7 or lower, an advance from 1:59:59 AM yields 3:00:00 AM.
- R8: With control bit 0 set, on a Sunday in October with date 25 or higher, the first advance from 1:59:59 AM yields 1:00:00 AM. A later pass on that day yields 2:00:00 AM.
- R9: A daylight-saving change applies only when the two advances before the trigger had no time-field write in between. Otherwise the hour steps normally.
- R10: Each advance is followed by `upd_pulse` high for exactly one clock. `upd_irq` equals that pulse when control bit 4 (update-ended enable) is set and is 0 otherwise.
- R11: The power-well reset clears control bit 4 and leaves control bits 0 to 2 unchanged. During reset and after it, no pulse is emitted until a strobe arrives.
- R12: Write addresses 0 to 6 select seconds, minutes, hours, day of week, date, month and year. A write in the same cycle as a strobe wins: the field takes the written value, no advance happens and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-well reset, active low |
| tick | input | 1 | One-second update strobe, one clock wide |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Write address, 0-6 time fields, 7 control |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field, bit 7 PM flag in 12-hour mode |
| dow_o | output | 8 | Day of week, 1 = Sunday |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year, 0-99 |
| cfg_o | output | 4 | {update-ended enable, binary mode, 24-hour mode, daylight-saving enable} |
| upd_pulse | output | 1 | Update-ended pulse |
| upd_irq | output | 1 | Update-ended pulse gated by the enable |

## Verification
Several rules are checked by assertions on every cycle. A pulse always follows a strobe that was not overridden by a write. A write cycle never produces a pulse. Minutes hold still unless seconds wrapped. The PM bit stays clear in 24-hour mode, and reset always clears the update-ended enable. The calendar arithmetic needs directed scenarios, because it depends on prepared times. These cover leap-year February, year and month wrap, the 12-hour meridian sequence, the spring skip, the single autumn repeat and its suppression on the second pass, and the history rule after a write.

// File: rtl/rtc_time_counter.sv
module rtc_time_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [3:0] cfg_o,
  output logic       upd_pulse,
  output logic       upd_irq
);

  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
  logic       uie_q, bin_q, h24_q, dse_q;
  logic [1:0] run_q;
  logic       fb_done_q, upd_q;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : ({3'd0, v[7:4]} * 7'd10 + {3'd0, v[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [7:0] w;
    w = {1'b0, v};
    return bin ? w : (((w / 8'd10) << 4) | (w % 8'd10));
  endfunction

  wire advance = tick & ~wr_en;

  logic [6:0] s_b, m_b, hv_b, dw_b, dt_b, mo_b, yr_b;
  logic       pm_in;
  logic [4:0] h24;

  assign s_b   = dec(sec_q, bin_q);
  assign m_b   = dec(min_q, bin_q);
  assign hv_b  = dec(h24_q ? hour_q : {1'b0, hour_q[6:0]}, bin_q);
  assign dw_b  = dec(dow_q, bin_q);
  assign dt_b  = dec(date_q, bin_q);
  assign mo_b  = dec(month_q, bin_q);
  assign yr_b  = dec(year_q, bin_q);
  assign pm_in = ~h24_q & hour_q[7];

  always_comb begin
    if (h24_q)           h24 = hv_b[4:0];
    else if (hv_b == 12) h24 = pm_in ? 5'd12 : 5'd0;
    else                 h24 = pm_in ? 5'(hv_b + 7'd12) : hv_b[4:0];
  end

  logic [6:0] mdays;
  always_comb begin
    case (mo_b)
      7'd4, 7'd6, 7'd9, 7'd11: mdays = 7'd30;
      7'd2:                    mdays = (yr_b[1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 mdays = 7'd31;
    endcase
  end

  wire at_trig = dse_q && (run_q == 2'd2) && (dw_b == 7'd1) &&
                 (h24 == 5'd1) && (m_b == 7'd59) && (s_b == 7'd59);
  wire spring  = at_trig && (mo_b == 7'd4)  && (dt_b <= 7'd7);
  wire fall    = at_trig && (mo_b == 7'd10) && (dt_b >= 7'd25) && !fb_done_q;

  logic [6:0] s_n, m_n, dw_n, dt_n, mo_n, yr_n;
  logic [4:0] h_n;
  logic       day_roll;

  always_comb begin
    s_n = s_b; m_n = m_b; h_n = h24;
    dw_n = dw_b; dt_n = dt_b; mo_n = mo_b; yr_n = yr_b;
    day_roll = 1'b0;
    if (spring || fall) begin
      s_n = 7'd0;
      m_n = 7'd0;
      h_n = spring ? 5'd3 : 5'd1;
    end else if (s_b != 7'd59) begin
      s_n = s_b + 7'd1;
    end else begin
      s_n = 7'd0;
      if (m_b != 7'd59) begin
        m_n = m_b + 7'd1;
      end else begin
        m_n = 7'd0;
        if (h24 != 5'd23) begin
          h_n = h24 + 5'd1;
        end else begin
          h_n = 5'd0;
          day_roll = 1'b1;
          dw_n = (dw_b >= 7'd7) ? 7'd1 : dw_b + 7'd1;
          if (dt_b < mdays) begin
            dt_n = dt_b + 7'd1;
          end else begin
            dt_n = 7'd1;
            if (mo_b < 7'd12) begin
              mo_n = mo_b + 7'd1;
            end else begin
              mo_n = 7'd1;
              yr_n = (yr_b >= 7'd99) ? 7'd0 : yr_b + 7'd1;
            end
          end
        end
      end
    end
  end

  logic [4:0] h12_n;
  logic [7:0] hour_n;
  always_comb begin
    h12_n = (h_n >= 5'd12) ? h_n - 5'd12 : h_n;
    if (h12_n == 5'd0) h12_n = 5'd12;
    if (h24_q) hour_n = enc({2'd0, h_n}, bin_q);
    else       hour_n = {(h_n >= 5'd12), enc({2'd0, h12_n}, bin_q)[6:0]};
  end

  wire time_wr = wr_en && (wr_addr != 3'd7);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_addr)
        3'd0: sec_q   <= wr_data;
        3'd1: min_q   <= wr_data;
        3'd2: hour_q  <= wr_data;
        3'd3: dow_q   <= wr_data;
        3'd4: date_q  <= wr_data;
        3'd5: month_q <= wr_data;
        3'd6: year_q  <= wr_data;
        default: begin
          bin_q <= wr_data[2];
          h24_q <= wr_data[1];
          dse_q <= wr_data[0];
        end
      endcase
    end else if (advance) begin
      sec_q   <= enc(s_n, bin_q);
      min_q   <= enc(m_n, bin_q);
      hour_q  <= hour_n;
      dow_q   <= enc(dw_n, bin_q);
      date_q  <= enc(dt_n, bin_q);
      month_q <= enc(mo_n, bin_q);
      year_q  <= enc(yr_n, bin_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uie_q     <= 1'b0;
      run_q     <= 2'd0;
      fb_done_q <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= advance;
      if (wr_en && wr_addr == 3'd7) uie_q <= wr_data[4];
      if (time_wr)                      run_q <= 2'd0;
      else if (advance && run_q != 2'd2) run_q <= run_q + 2'd1;
      if (advance && fall)          fb_done_q <= 1'b1;
      else if (advance && day_roll) fb_done_q <= 1'b0;
    end
  end

  assign sec_o     = sec_q;
  assign min_o     = min_q;
  assign hour_o    = hour_q;
  assign dow_o     = dow_q;
  assign date_o    = date_q;
  assign month_o   = month_q;
  assign year_o    = year_q;
  assign cfg_o     = {uie_q, bin_q, h24_q, dse_q};
  assign upd_pulse = upd_q;
  assign upd_irq   = upd_q & uie_q;

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(tick && !wr_en)); // R10
  AST_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !upd_pulse); // R12
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && $past(sec_o) != (cfg_o[2] ? 8'd59 : 8'h59)) |-> $stable(min_o)); // R4
  AST_NO_PM_24H: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && cfg_o[1]) |-> !hour_o[7]); // R2
  AST_UIE_CLEARED: assert property (@(posedge clk)
    !rst_n |-> !cfg_o[3] && !upd_irq); // R11

endmodule

// File: tb/rtc_time_counter_tb.sv
module rtc_time_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [3:0] cfg_o;
  logic upd_pulse, upd_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .cfg_o(cfg_o), .upd_pulse(upd_pulse), .upd_irq(upd_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, dt, dw, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic step;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 pulse idle in reset", upd_pulse, 0);
    chk("R11 irq idle in reset", upd_irq, 0);
    chk("R11 enable cleared", cfg_o[3], 0);
  endtask

  task automatic t_bcd_year_roll;
    wr(3'd7, 8'h02);
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    step;
    chk("R2 hour 23 wraps", hour_o, 8'h00);
    chk("R4 sec wrap", sec_o, 8'h00);
    chk("R4 min wrap", min_o, 8'h00);
    chk("R6 dow 7 to 1", dow_o, 8'h01);
    chk("R5 date wrap", date_o, 8'h01);
    chk("R5 month wrap", month_o, 8'h01);
    chk("R5 year wrap", year_o, 8'h00);
  endtask

  task automatic t_formats;
    wr(3'd7, 8'h02);
    wr(3'd0, 8'h09); step;
    chk("R1 BCD seconds", sec_o, 8'h10);
    chk("R4 min held", min_o, 8'h00);
    wr(3'd7, 8'h06);
    wr(3'd0, 8'd9); step;
    chk("R1 binary seconds", sec_o, 8'h0A);
  endtask

  task automatic t_leap;
    wr(3'd7, 8'h06);
    set_time(8'd4, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59); step;
    chk("R5 leap Feb 29", date_o, 8'd29);
    chk("R5 leap month kept", month_o, 8'd2);
    chk("R6 dow step", dow_o, 8'd4);
    set_time(8'd5, 8'd2, 8'd28, 8'd3, 8'd23, 8'd59, 8'd59); step;
    chk("R5 common Feb date", date_o, 8'd1);
    chk("R5 common Feb month", month_o, 8'd3);
  endtask

  task automatic t_12h;
    wr(3'd7, 8'h00);
    set_time(8'h05, 8'h06, 8'h10, 8'h03, 8'h11, 8'h59, 8'h59); step;
    chk("R3 11AM to 12PM", hour_o, 8'h92);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59); step;
    chk("R3 12PM to 1PM", hour_o, 8'h81);
    wr(3'd2, 8'h91); wr(3'd1, 8'h59); wr(3'd0, 8'h59); step;
    chk("R3 11PM to 12AM", hour_o, 8'h12);
    chk("R3 date advances", date_o, 8'h11);
  endtask

  task automatic t_spring;
    wr(3'd7, 8'h03);
    set_time(8'h05, 8'h04, 8'h03, 8'h01, 8'h01, 8'h59, 8'h57);
    step; step; step;
    chk("R7 skip to 3", hour_o, 8'h03);
    chk("R7 minutes zero", min_o, 8'h00);
    chk("R7 seconds zero", sec_o, 8'h00);
  endtask

  task automatic t_history;
    wr(3'd7, 8'h03);
    set_time(8'h05, 8'h04, 8'h03, 8'h01, 8'h01, 8'h59, 8'h59);
    step;
    chk("R9 no skip after write", hour_o, 8'h02);
  endtask

  task automatic t_fall;
    wr(3'd7, 8'h03);
    set_time(8'h05, 8'h10, 8'h30, 8'h01, 8'h01, 8'h59, 8'h57);
    step; step; step;
    chk("R8 back to 1", hour_o, 8'h01);
    chk("R8 minutes zero", min_o, 8'h00);
    wr(3'd1, 8'h59); wr(3'd0, 8'h57);
    step; step; step;
    chk("R8 second pass normal", hour_o, 8'h02);
  endtask

  task automatic t_pulse;
    wr(3'd7, 8'h12);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R10 pulse high", upd_pulse, 1);
    chk("R10 irq with enable", upd_irq, 1);
    @(negedge clk);
    chk("R10 pulse one clock", upd_pulse, 0);
    wr(3'd7, 8'h02); step;
    chk("R10 pulse without enable", upd_pulse, 1);
    chk("R10 irq gated off", upd_irq, 0);
  endtask

  task automatic t_write_wins;
    wr(3'd7, 8'h02);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R12 written value kept", sec_o, 8'h30);
    chk("R12 no pulse", upd_pulse, 0);
  endtask

  task automatic t_reset_keeps;
    wr(3'd7, 8'h17);
    chk("R11 cfg before reset", cfg_o, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 modes kept, enable cleared", cfg_o, 4'h7);
    chk("R11 no pulse after reset", upd_pulse, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_bcd_year_roll;
    t_formats;
    t_leap;
    t_12h;
    t_spring;
    t_history;
    t_fall;
    t_pulse;
    t_write_wins;
    t_reset_keeps;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule